// File: doc/BRIEF.md
# Serial Register Control Port

This block is a slave serial-peripheral port that lets a host read and write a small register file inside the chip. The host lowers chip select and clocks bytes in on the data input, most significant bit first. The first byte holds a fixed 7-bit device address in its upper seven bits and a direction bit in bit 0. In a write, the second byte loads a register pointer and every later byte is stored at the pointer, which then steps forward. In a read, the port returns bytes starting at the pointer left by the most recent write, again stepping forward after each byte. Raising chip select ends the transaction at any point.

The serial clock, select and data input are oversampled by the local clock through synchronizers, so the serial clock must run well below the local clock (each serial clock phase at least four local cycles). The data output changes only after falling serial clock edges, and it is driven only while read data is being shifted. The `spi_miso_oe` pin carries the output enable for the pad's tri-state driver. The writable registers appear in parallel on `reg_q` for the logic they configure. A read-only identification register holds a fixed device code and a revision code.

This is a control port, not a data stream, so it has no valid/ready handshake. The host sets the pace through the serial clock and cannot be stalled.

Top module: `spi_ctrl_port`

## Requirements
- R1: The first byte of a transaction is taken as a device address in bits 7..1 and a direction bit in bit 0 (0 = write, 1 = read). The port responds only when bits 7..1 equal binary 0010000, so a write starts with byte 0x20 and a read with byte 0x21.
- R2: Input bits are sampled on rising serial clock edges while chip select is low, most significant bit first.
- R3: In a write, the second byte loads bits 6..0 into the register pointer (bit 7 is ignored). Each further complete byte is stored at the pointer, and the pointer then increments. Register k (0 ≤ k < NUM_REGS) appears on `reg_q[8k+7:8k]`.
- R4: A read returns bytes starting at the pointer left by the earlier transactions, and the pointer increments after each byte. Bits go out most significant first, and the output changes only after a falling serial clock edge, so it is valid before the next rising edge.
- R5: `spi_miso_oe` is high only while read data is shifted out (from the first falling edge after the read address byte), and it drops after chip select rises.
- R6: When the device address does not match, the rest of the transaction is ignored. No register changes, the pointer is unchanged, and `spi_miso_oe` stays low.
- R7: Address 0x7F reads as 0x2 in bits 7..4 and the REVISION parameter in bits 3..0. Writes to it, or to any address at or above NUM_REGS, change nothing and still increment the pointer. Unmapped addresses read as 0x00.
- R8: The pointer wraps from 0x7F to 0x00.
- R9: Raising chip select in the middle of a byte discards the partial byte.
- R10: After reset, all registers read 0x00, the pointer is 0x00 and `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | Output enable for the read data pad |
| reg_q | output | NUM_REGS*8 | Writable registers, register 0 in the low byte |

## Verification
The hardest states to reach are the ones where the pointer is carried across transactions. A read has no address of its own, so a wrap from 0x7F to 0x00, a burst across the read-only and unmapped region, and a write cut off mid-byte show up only in a later read. The bench reaches them with write bursts aimed at 0x7E, truncated transactions and mismatched address bytes, each followed by a read. A reference model of the register array and pointer, updated alongside the stimulus, supplies the expected values. Random bursts of random length and start address, drawn from a fixed seed, run between these directed cases.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam logic [6:0] DEV_ADDR = 7'b0010000;
  localparam logic [3:0] DEV_CODE = 4'b0010;
  localparam logic [6:0] ID_ADDR  = 7'h7F;

  typedef enum logic [2:0] {
    PH_DEVADDR,
    PH_POINTER,
    PH_WRDATA,
    PH_RDDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_ctrl_sync.sv
module spi_ctrl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  input  logic [WIDTH-1:0] reset_val,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= reset_val;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_ctrl_pkg::*;
#(
  parameter int          NUM_REGS = 8,
  parameter logic [3:0]  REVISION = 4'h3,
  localparam int         AW       = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                regs_flat[g*8 +: 8] <= 8'h00;
        else if (wr_en && wr_addr == AW'(g))       regs_flat[g*8 +: 8] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == ID_ADDR) rd_data = {DEV_CODE, REVISION};
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == AW'(i)) rd_data = regs_flat[i*8 +: 8];
  end

  // R7
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> $stable(regs_flat));
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
  import spi_ctrl_pkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter logic [3:0] REVISION    = 4'h3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sck,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic                  spi_miso_oe,
  output logic [NUM_REGS*8-1:0] reg_q
);
  localparam int AW = 7;

  logic [2:0]    pins_s;
  logic          sck_s, cs_s, mosi_s, sck_d;
  logic          sck_rise, sck_fall, byte_end;
  phase_t        phase;
  logic [2:0]    bit_cnt;
  logic [6:0]    shreg;
  logic [7:0]    in_byte, tx_byte, rd_data;
  logic [AW-1:0] ptr, ptr_inc, rd_addr;
  logic          wr_en;

  spi_ctrl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  ({spi_sck, spi_cs_n, spi_mosi}),
    .reset_val (3'b010),
    .sync_out  (pins_s)
  );
  assign {sck_s, cs_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_s;
  assign in_byte  = {shreg, mosi_s};
  assign byte_end = sck_rise && (bit_cnt == 3'd7);
  assign ptr_inc  = ptr + AW'(1);
  assign rd_addr  = (phase == PH_RDDATA) ? ptr_inc : ptr;
  assign wr_en    = byte_end && (phase == PH_WRDATA);

  spi_ctrl_regs #(.NUM_REGS(NUM_REGS), .REVISION(REVISION)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (ptr),
    .wr_data   (in_byte),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .regs_flat (reg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_DEVADDR;
      bit_cnt     <= 3'd0;
      shreg       <= 7'd0;
      tx_byte     <= 8'h00;
      ptr         <= '0;
      spi_miso    <= 1'b0;
      spi_miso_oe <= 1'b0;
    end else if (cs_s) begin
      phase       <= PH_DEVADDR;
      bit_cnt     <= 3'd0;
      spi_miso_oe <= 1'b0;
    end else begin
      if (sck_rise) begin
        shreg   <= in_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_end) begin
        unique case (phase)
          PH_DEVADDR: begin
            if (in_byte[7:1] != DEV_ADDR) phase <= PH_SKIP;
            else if (in_byte[0]) begin
              phase   <= PH_RDDATA;
              tx_byte <= rd_data;
            end else phase <= PH_POINTER;
          end
          PH_POINTER: begin
            ptr   <= in_byte[AW-1:0];
            phase <= PH_WRDATA;
          end
          PH_WRDATA: ptr <= ptr_inc;
          PH_RDDATA: begin
            ptr     <= ptr_inc;
            tx_byte <= rd_data;
          end
          default: phase <= PH_SKIP;
        endcase
      end
      if (sck_fall && phase == PH_RDDATA) begin
        spi_miso    <= tx_byte[7];
        tx_byte     <= {tx_byte[6:0], 1'b0};
        spi_miso_oe <= 1'b1;
      end
    end
  end

  // R5
  oe_drop_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> !spi_miso_oe);
  // R5
  oe_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> (phase == PH_RDDATA || $past(cs_s) == 1'b0));
  // R6
  skip_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!spi_miso_oe && !wr_en));
  // R4
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso_oe && !$stable(spi_miso)) |-> $past(sck_fall));
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && (phase == PH_WRDATA || phase == PH_RDDATA)) |=> (ptr == AW'($past(ptr) + AW'(1))));
endmodule

// File: tb/tb_spi_ctrl_port.sv
`timescale 1ns/1ps
module tb_spi_ctrl_port;
  localparam int         NUM_REGS = 8;
  localparam logic [3:0] REV      = 4'h3;
  localparam int         HALF     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic [NUM_REGS*8-1:0] reg_q;

  int checks = 0, errors = 0;
  logic [7:0] mem [NUM_REGS];
  logic [6:0] mptr;

  always #4 clk = ~clk;

  spi_ctrl_port #(.NUM_REGS(NUM_REGS), .REVISION(REV), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .reg_q(reg_q)
  );

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [7:0] model_rd(input logic [6:0] a);
    if (a == 7'h7F) return {4'b0010, REV};
    if (int'(a) < NUM_REGS) return mem[a];
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    sck = 1'b0; cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic desel();
    cs_n = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
  endtask

  // One byte; oe is checked before each rising edge against exp_oe
  task automatic xfer(input logic [7:0] tx, input logic exp_oe, input string tag,
                      output logic [7:0] rx);
    int bad = 0;
    for (int b = 7; b >= 0; b--) begin
      sck = 1'b0; mosi = tx[b]; wait_clk(HALF);
      if (miso_oe !== exp_oe) bad++;
      rx[b] = miso;
      sck = 1'b1; wait_clk(HALF);
    end
    chk({tag, " R5 oe"}, 32'(bad), 32'd0);
  endtask

  task automatic do_write(input logic [6:0] addr, input int n, input logic [7:0] d [16]);
    logic [7:0] rx;
    sel();
    xfer(8'h20, 1'b0, "R1 wr addr", rx);
    xfer({1'b1, addr}, 1'b0, "R3 ptr", rx);   // bit 7 ignored
    mptr = addr;
    for (int i = 0; i < n; i++) begin
      xfer(d[i], 1'b0, "R3 data", rx);
      if (int'(mptr) < NUM_REGS) mem[mptr] = d[i];
      mptr = mptr + 7'd1;
    end
    desel();
  endtask

  task automatic do_read(input int n, input string tag);
    logic [7:0] rx;
    sel();
    xfer(8'h21, 1'b0, "R1 rd addr", rx);
    for (int i = 0; i < n; i++) begin
      xfer(8'hFF, 1'b1, tag, rx);
      chk({tag, " R4 data"}, 32'(rx), 32'(model_rd(mptr)));
      mptr = mptr + 7'd1;
    end
    desel();
    chk("R5 oe after cs", 32'(miso_oe), 32'd0);
  endtask

  task automatic check_regq(input string tag);
    for (int i = 0; i < NUM_REGS; i++)
      chk({tag, " R3 reg_q"}, 32'(reg_q[i*8 +: 8]), 32'(mem[i]));
  endtask

  initial begin
    logic [7:0] d [16];
    logic [7:0] rx;
    int unused;
    unused = $urandom(32'd1234);
    for (int i = 0; i < NUM_REGS; i++) mem[i] = 8'h00;
    mptr = 7'd0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R10 reset state
    chk("R10 oe", 32'(miso_oe), 32'd0);
    chk("R10 reg_q", 32'(reg_q), 32'd0);
    do_read(2, "R10 read");

    // R2 R3 R4 directed burst
    for (int i = 0; i < 16; i++) d[i] = 8'(8'hA5 ^ (i * 37));
    do_write(7'd1, 4, d);
    check_regq("R3 burst");
    mptr = 7'd5;
    do_read(3, "R4 cont");

    // R7 ID register read and write ignored
    d[0] = 8'h55;
    do_write(7'h7F, 1, d);
    mptr = 7'h7F;
    sel(); xfer(8'h20, 1'b0, "R7 setptr", rx); xfer(8'h7F, 1'b0, "R7 setptr", rx); desel();
    do_read(1, "R7 id");
    chk("R7 id value", 32'(model_rd(7'h7F)), 32'h23);

    // R8 wrap across unmapped and ID into 0x00
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'hC3; d[3] = 8'h3C;
    do_write(7'h7E, 4, d);
    check_regq("R8 wrap");
    chk("R8 reg0", 32'(reg_q[7:0]), 32'hC3);
    sel(); xfer(8'h20, 1'b0, "R8 setptr", rx); xfer(8'h7E, 1'b0, "R8 setptr", rx); desel();
    mptr = 7'h7E;
    do_read(4, "R8 rdwrap");

    // R6 mismatched device address, write then read form
    sel();
    xfer(8'h22, 1'b0, "R6 badaddr", rx);
    xfer(8'h00, 1'b0, "R6 ptr", rx);
    xfer(8'hEE, 1'b0, "R6 data", rx);
    desel();
    check_regq("R6 nowrite");
    sel();
    xfer(8'hA1, 1'b0, "R6 badrd", rx);
    xfer(8'hFF, 1'b0, "R6 badrd data", rx);
    desel();
    do_read(1, "R6 ptr kept");

    // R9 partial byte discarded
    sel();
    xfer(8'h20, 1'b0, "R9 addr", rx);
    xfer(8'h03, 1'b0, "R9 ptr", rx);
    for (int b = 7; b >= 4; b--) begin
      sck = 1'b0; mosi = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
    end
    desel();
    mptr = 7'd3;
    check_regq("R9 partial");
    do_read(1, "R9 read");

    // Constrained random bursts
    for (int it = 0; it < 25; it++) begin
      int n, m;
      logic [6:0] a;
      n = int'($urandom_range(0, 5));
      m = int'($urandom_range(1, 5));
      a = ($urandom_range(0, 3) == 0) ? 7'(7'h7C + $urandom_range(0, 3))
                                      : 7'($urandom_range(0, NUM_REGS + 1));
      for (int i = 0; i < 16; i++) d[i] = 8'($urandom);
      do_write(a, n, d);
      check_regq("R3 rand");
      do_read(m, "R4 rand");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule